// File: doc/BRIEF.md
# Programmable Divider from Cascaded 2/3 Cells

This block divides a clock into one output pulse per programmable number of clocks. It is built from a chain of identical divide-by-2/3 cells. The first cell runs on every clock. Each later cell advances once per output period of the cell before it. A cell normally spends two of its input periods per output period. It spends three when it is told to absorb an extra period.

Each cell sends a qualifying signal back to the faster cell in front of it. The cell registers this signal itself, so there is no shared gating network that watches every stage. The slowest cell treats its own incoming qualifier as always active. The faster cells each take theirs from their slower neighbour. The registered qualifier of the fastest cell is the block's output pulse.

With `N_CELLS` cells and a program word P, the output period is 2^N_CELLS + P clocks. This covers every value from 2^N_CELLS to 2^(N_CELLS+1)-1 with no gaps. The program word is sampled once per output period, so a new ratio takes effect cleanly.

Top module: `mod23_divider`

## Requirements
- R1: The output period, counted in `clk_i` cycles between rising edges of `out_o`, equals 2^N_CELLS + `prog_i`. Bit k of `prog_i` is weighted 2^k.
- R2: Every program word from 0 to 2^N_CELLS-1 gives its own period, so the reachable periods form the contiguous range 2^N_CELLS to 2^(N_CELLS+1)-1.
- R3: `out_o` is high for exactly one clock cycle per output period.
- R4: `prog_i` is sampled only on the clock edge that ends an output period, which is the edge where `out_o` is high. A change at any other time first affects the period that starts after the next such edge.
- R5: While `rst_ni` is low, `out_o` is low and the stored program word is zero. The first period after reset therefore ends with `out_o` high in cycle 2^N_CELLS-1 after release, and the word present at that edge sets the second period.
- R6: A cell absorbs a third input period only when both its program bit and its incoming qualifier are high.
- R7: A cell raises its outgoing qualifier only while its incoming qualifier is high. The qualifier stays high for exactly one of the cell's input periods, and then falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_i | input | N_CELLS | Program word added to 2^N_CELLS |
| out_o | output | 1 | One-cycle pulse per output period |

## Verification
The cell assertions assume two things. First, a cell's incoming qualifier and program bit do not change within one of its output periods. Second, a slower cell is only advanced by period ends of the faster cell. The design meets both because every qualifier is updated only when its cell advances, and the stored program word changes only at the edge that ends the whole period.

The bench drives `prog_i` only at the falling edge that follows a pulse, or at a chosen point in the middle of a period. Its capture checks therefore always know which period a new word belongs to. It sweeps every word for a three-cell chain and for a four-cell chain.

// File: rtl/mod23_pkg.sv
package mod23_pkg;
  localparam int unsigned CNT_W = 2;
  typedef logic [CNT_W-1:0] cnt_t;
  localparam cnt_t LAST_NORMAL  = cnt_t'(1);
  localparam cnt_t LAST_SWALLOW = cnt_t'(2);
endpackage

// File: rtl/mod23_prog_reg.sv
module mod23_prog_reg #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

  // R4
  hold_between_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/mod23_cell.sv
module mod23_cell
  import mod23_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic modin_i,
  input  logic prog_bit_i,
  output logic tick_o,
  output logic modout_o
);
  cnt_t cnt_q;
  cnt_t cnt_inc;
  cnt_t last_idx;
  logic at_last;
  logic mod_q;

  // extra input period only in the qualified period with the bit set
  assign last_idx = (modin_i && prog_bit_i) ? LAST_SWALLOW : LAST_NORMAL;
  assign at_last  = (cnt_q == last_idx);
  assign cnt_inc  = cnt_q + cnt_t'(1);
  assign tick_o   = tick_i && at_last;
  assign modout_o = mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= 1'b0;
    end else if (tick_i) begin
      if (at_last) begin
        cnt_q <= '0;
        mod_q <= 1'b0;
      end else begin
        cnt_q <= cnt_inc;
        mod_q <= modin_i && (cnt_inc == last_idx);
      end
    end
  end

  // R6
  swallow_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST_SWALLOW) |-> (modin_i && prog_bit_i));

  // R7
  modout_needs_modin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_q |-> modin_i);

  // R7
  modout_one_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_q && tick_i) |=> !mod_q);
endmodule

// File: rtl/mod23_divider.sv
module mod23_divider
  import mod23_pkg::*;
#(
  parameter int unsigned N_CELLS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CELLS-1:0] prog_i,
  output logic               out_o
);
  logic [N_CELLS:0]   tick;
  logic [N_CELLS:0]   mod;
  logic [N_CELLS-1:0] prog_q;

  assign tick[0]       = 1'b1;
  assign mod[N_CELLS]  = 1'b1;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    mod23_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick[i]),
      .modin_i    (mod[i+1]),
      .prog_bit_i (prog_q[i]),
      .tick_o     (tick[i+1]),
      .modout_o   (mod[i])
    );
  end

  mod23_prog_reg #(.WIDTH(N_CELLS)) u_prog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tick[N_CELLS]),
    .d_i    (prog_i),
    .q_o    (prog_q)
  );

  assign out_o = mod[0];

  // R3
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o |=> !out_o);

  // R4
  pulse_marks_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o |-> tick[N_CELLS]);
endmodule

// File: tb/mod23_divider_tb.sv
`timescale 1ns/1ps
module mod23_divider_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] prog3 = '0;
  logic [3:0] prog4 = '0;
  logic       out3;
  logic       out4;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  mod23_divider #(.N_CELLS(3)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prog_i(prog3), .out_o(out3));
  mod23_divider #(.N_CELLS(4)) u_dut4 (
    .clk_i(clk), .rst_ni(rst_n), .prog_i(prog4), .out_o(out4));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pulse(input int sel);
    return (sel == 4) ? out4 : out3;
  endfunction

  task automatic set_prog(input int sel, input int w);
    if (sel == 4) prog4 = 4'(w);
    else          prog3 = 3'(w);
  endtask

  // called at a negedge; returns number of negedges until the next pulse
  task automatic next_pulse(input int sel, output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!pulse(sel) && len < 100);
  endtask

  task automatic run_sel(input int sel);
    int base = 1 << sel;
    int len;
    // R5: reset state
    set_prog(sel, 5);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 out low in reset", int'(pulse(sel)), 0);
    rst_n = 1'b1;
    next_pulse(sel, len);
    chk("R5 first period", len, base - 1);
    next_pulse(sel, len);
    chk("R5 second period uses word at first edge", len, base + 5);
    // R1/R2 sweep every word; at a pulse negedge the new word is captured next edge
    for (int w = 0; w < base; w++) begin
      set_prog(sel, w);
      @(negedge clk);
      chk("R3 pulse one cycle wide", int'(pulse(sel)), 0);
      begin
        int l2;
        next_pulse(sel, l2);
        chk("R1 R2 period matches word", l2 + 1, base + w);
      end
    end
    // R4: mid-period change keeps the current period
    set_prog(sel, 1);
    repeat (3) @(negedge clk);
    set_prog(sel, base - 1);
    next_pulse(sel, len);
    chk("R4 mid-period change ignored", len + 3, base + 1);
    next_pulse(sel, len);
    chk("R4 new word next period", len, 2 * base - 1);
    set_prog(sel, 0);
    next_pulse(sel, len);
    chk("R1 word zero", len, base);
  endtask

  initial begin
    run_sel(3);
    run_sel(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule